// File: doc/BRIEF.md
# Supervisor Reset and Power-Fail Output Sequencer

This block drives the processor reset line and the early power-fail warning for a memory-backup supervisor. Its inputs are already digitized: a flag that is high while the supply sits above the deselect threshold, a level from the power-fail comparator, and an active-low manual reset pin. The only time base is a one-cycle tick from a shared prescaler. The reset output is an open-drain enable: a 1 pulls the external reset line low.

A loss of supply forces reset and pulls the warning output low. When the supply returns, both outputs are held for a recovery interval of a set number of ticks. During that interval reset stays asserted and the warning output is forced high, whatever the comparator reports. After the interval, reset releases and the warning output follows the comparator.

A manual reset pulse that lasts at least the qualification width gives the same sequence as a power cycle. The recovery interval is timed from the rising edge that ends the pulse. Glitches shorter than that width are filtered out.

Top module: `supv_reset_seq`

## Requirements
- R1: One clock after `supplyOk` is sampled low, `rstPullDown` is 1. It stays 1 for as long as `supplyOk` stays low, whatever `mrN` does.
- R2: After `supplyOk` rises, `rstPullDown` stays 1 until REC_TICKS ticks have been sampled in the recovery state. It is 0 from the cycle after the edge that samples the last of those ticks.
- R3: A low level on `mrN` that lasts at least MR_QUAL_CYC cycles asserts `rstPullDown` MR_QUAL_CYC+SYNC_STAGES+1 cycles after the falling edge. Reset is held while `mrN` stays low. Recovery starts SYNC_STAGES+1 cycles after `mrN` returns high and then lasts REC_TICKS ticks, as in R2.
- R4: A low pulse on `mrN` shorter than MR_QUAL_CYC cycles has no effect on either output.
- R5: `pfOut` is 0 from one clock after `supplyOk` is sampled low, for as long as the supply stays low.
- R6: While a manual reset is held, and during every recovery interval, `pfOut` is 1 regardless of `pfCmp`.
- R7: Once reset has released, `pfOut` equals `pfCmp` in the same cycle, with no register in between. `pfCmp` is 1 when the monitored input is above its threshold.
- R8: A qualifying manual pulse that arrives during a recovery interval restarts the interval. The full REC_TICKS ticks then count again from the pulse's release.
- R9: While `rstN` is low, `rstPullDown` is 1 and `pfOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| tick | input | 1 | One-cycle pulse from the shared prescaler; the unit of recovery time |
| supplyOk | input | 1 | 1 while the supply is above the deselect threshold |
| mrN | input | 1 | Manual reset pin, active low, idles high |
| pfCmp | input | 1 | Power-fail comparator result, 1 = input above threshold |
| rstPullDown | output | 1 | Open-drain enable for the reset line, 1 = drive reset low |
| pfOut | output | 1 | Power-fail warning output, 0 = failing |

## Verification
A supply change shows on both outputs one clock after the edge that samples it. A manual press has a longer path: SYNC_STAGES synchronizer flops plus the width counter put the assertion of reset at cycle MR_QUAL_CYC+SYNC_STAGES+1, and the start of recovery at SYNC_STAGES+1 cycles after release. The release of reset comes one clock after the edge that samples the REC_TICKS-th tick in the recovery state. The bench drives at the falling edge and samples just after it, then queues an expected value for every cycle. It counts ticks only from the computed entry cycle, so each comparison falls in exactly the cycle these latencies give. The comparator follow-through has no register, so it is checked within the same cycle as the `pfCmp` change.

// File: rtl/supv_pkg.sv
package supv_pkg;

  typedef enum logic [1:0] {
    ST_DOWN    = 2'd0,  // supply below deselect threshold
    ST_HOLD    = 2'd1,  // manual reset held low
    ST_RECOVER = 2'd2,  // recovery interval running
    ST_RUN     = 2'd3   // normal operation
  } supvState_t;

  // strobes from control to the timing datapath
  typedef struct packed {
    logic clrRec;  // clear the recovery tick counter
    logic cntRec;  // count prescaler ticks toward recovery
  } recStrobe_t;

endpackage

// File: rtl/supv_datapath.sv
module supv_datapath
  import supv_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MR_QUAL_CYC = 10,
  parameter int REC_TICKS   = 140
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       mrN,
  input  recStrobe_t strobe,
  output logic       mrSync,
  output logic       mrQual,
  output logic       recDone
);

  localparam int MR_W  = $clog2(MR_QUAL_CYC + 1);
  localparam int REC_W = $clog2(REC_TICKS + 1);
  localparam logic [MR_W-1:0]  MR_LIMIT  = MR_W'(MR_QUAL_CYC);
  localparam logic [REC_W-1:0] REC_LAST  = REC_W'(REC_TICKS - 1);

  // manual reset synchronizer, idles high
  logic [SYNC_STAGES-1:0] mrPipe;
  generate
    if (SYNC_STAGES == 1) begin : gSyncOne
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) mrPipe <= '1;
        else       mrPipe <= mrN;
      end
    end else begin : gSyncMany
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) mrPipe <= '1;
        else       mrPipe <= {mrPipe[SYNC_STAGES-2:0], mrN};
      end
    end
  endgenerate
  assign mrSync = mrPipe[SYNC_STAGES-1];

  // width filter: consecutive low cycles, saturating at the limit
  logic [MR_W-1:0] mrLowCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    mrLowCnt <= '0;
    else if (mrSync)              mrLowCnt <= '0;
    else if (mrLowCnt != MR_LIMIT) mrLowCnt <= mrLowCnt + 1'b1;
  end
  assign mrQual = (mrLowCnt == MR_LIMIT);

  // recovery interval counter in prescaler ticks
  logic [REC_W-1:0] recCnt;
  assign recDone = strobe.cntRec && tick && (recCnt == REC_LAST);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       recCnt <= '0;
    else if (strobe.clrRec)          recCnt <= '0;
    else if (strobe.cntRec && tick && !recDone) recCnt <= recCnt + 1'b1;
  end

  assert_rec_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    recCnt <= REC_LAST);
  assert_mr_filter_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    mrLowCnt <= MR_LIMIT);
  assert_mr_clear_on_high_R4: assert property (@(posedge clk) disable iff (!rstN)
    mrSync |=> (mrLowCnt == '0));

endmodule

// File: rtl/supv_ctrl.sv
module supv_ctrl
  import supv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyOk,
  input  logic       mrSync,
  input  logic       mrQual,
  input  logic       recDone,
  input  logic       pfCmp,
  output recStrobe_t strobe,
  output logic       rstAssert,
  output logic       pfDrive
);

  supvState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    if (!supplyOk) begin
      stateD = ST_DOWN;
    end else begin
      unique case (stateQ)
        ST_DOWN:    stateD = mrQual ? ST_HOLD : ST_RECOVER;
        ST_HOLD:    stateD = mrSync ? ST_RECOVER : ST_HOLD;
        ST_RECOVER: stateD = mrQual ? ST_HOLD : (recDone ? ST_RUN : ST_RECOVER);
        ST_RUN:     stateD = mrQual ? ST_HOLD : ST_RUN;
        default:    stateD = ST_DOWN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_DOWN;
    else       stateQ <= stateD;
  end

  always_comb begin
    strobe.cntRec = (stateQ == ST_RECOVER);
    strobe.clrRec = (stateQ != ST_RECOVER);
  end

  assign rstAssert = (stateQ != ST_RUN);
  assign pfDrive   = (stateQ == ST_RUN) ? pfCmp : (stateQ != ST_DOWN);

  assert_hold_entry_qualified_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_HOLD) && ($past(stateQ) != ST_HOLD) |-> $past(mrQual));
  assert_run_entry_after_count_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_RUN) && ($past(stateQ) != ST_RUN) |-> $past(recDone));
  assert_recover_restart_R8: assert property (@(posedge clk) disable iff (!rstN)
    supplyOk && mrQual && (stateQ == ST_RECOVER) |=> (stateQ == ST_HOLD));

endmodule

// File: rtl/supv_reset_seq.sv
module supv_reset_seq
  import supv_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MR_QUAL_CYC = 10,
  parameter int REC_TICKS   = 140
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic supplyOk,
  input  logic mrN,
  input  logic pfCmp,
  output logic rstPullDown,
  output logic pfOut
);

  recStrobe_t strobe;
  logic mrSync, mrQual, recDone;

  supv_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .MR_QUAL_CYC(MR_QUAL_CYC),
    .REC_TICKS  (REC_TICKS)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .tick   (tick),
    .mrN    (mrN),
    .strobe (strobe),
    .mrSync (mrSync),
    .mrQual (mrQual),
    .recDone(recDone)
  );

  supv_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .supplyOk (supplyOk),
    .mrSync   (mrSync),
    .mrQual   (mrQual),
    .recDone  (recDone),
    .pfCmp    (pfCmp),
    .strobe   (strobe),
    .rstAssert(rstPullDown),
    .pfDrive  (pfOut)
  );

  assert_reset_on_supply_loss_R1: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> rstPullDown);
  assert_pf_low_on_supply_loss_R5: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> !pfOut);
  assert_release_on_tick_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rstPullDown) |-> $past(tick) && $past(supplyOk));
  assert_pf_follows_when_running_R7: assert property (@(posedge clk) disable iff (!rstN)
    !rstPullDown |-> (pfOut == pfCmp));

endmodule

// File: tb/supv_reset_seq_tb.sv
module supv_reset_seq_tb;

  localparam int SYNC     = 2;
  localparam int QUAL     = 8;
  localparam int REC      = 6;
  localparam int TICK_DIV = 5;

  logic clk = 1'b0;
  logic rstN, tick, supplyOk, mrN, pfCmp;
  logic rstPullDown, pfOut;

  always #10 clk = ~clk;  // 50 MHz

  supv_reset_seq #(
    .SYNC_STAGES(SYNC),
    .MR_QUAL_CYC(QUAL),
    .REC_TICKS  (REC)
  ) u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .tick       (tick),
    .supplyOk   (supplyOk),
    .mrN        (mrN),
    .pfCmp      (pfCmp),
    .rstPullDown(rstPullDown),
    .pfOut      (pfOut)
  );

  typedef struct {
    logic  rst;
    logic  pf;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  event     chkEv;
  int       nChecks = 0;
  int       nFail   = 0;
  bit       done    = 0;

  // prescaler model: one-cycle tick every TICK_DIV clocks
  initial begin
    int div;
    div  = 0;
    tick = 1'b0;
    forever begin
      @(negedge clk);
      div  = (div == TICK_DIV - 1) ? 0 : div + 1;
      tick = (div == TICK_DIV - 1);
    end
  end

  // monitor: pop expected items and compare with the outputs
  initial begin
    forever begin
      @(chkEv);
      while (expQ.size() != 0) begin
        expItem_t it;
        it = expQ.pop_front();
        nChecks++;
        if (rstPullDown !== it.rst || pfOut !== it.pf) begin
          nFail++;
          $display("FAIL %s: rstPullDown=%b pfOut=%b expected rstPullDown=%b pfOut=%b at %0t",
                   it.tag, rstPullDown, pfOut, it.rst, it.pf, $time);
        end
      end
    end
  end

  task automatic step();
    @(negedge clk);
    #2;
  endtask

  task automatic expectOut(input logic r, input logic p, input string tag);
    expItem_t it;
    it.rst = r;
    it.pf  = p;
    it.tag = tag;
    expQ.push_back(it);
    ->chkEv;
    #0;
  endtask

  // lead = cycles until the recovery state is entered; ticks count from there
  task automatic recoverCheck(input int lead, input string tag);
    int cnt;
    cnt = 0;
    for (int k = 1; k < 200; k++) begin
      logic er;
      step();
      er = (k < lead) ? 1'b1 : ((cnt < REC) ? 1'b1 : 1'b0);
      expectOut(er, er ? 1'b1 : pfCmp, tag);
      if (!er) break;
      if (k >= lead && tick) cnt++;
    end
  endtask

  task automatic manualPress(input int width, input string tag, input bit inReset);
    mrN = 1'b0;
    for (int k = 1; k <= width; k++) begin
      logic er;
      step();
      er = inReset || (k >= QUAL + SYNC + 1);
      expectOut(er, er ? 1'b1 : pfCmp, tag);
    end
    mrN = 1'b1;
  endtask

  initial begin
    rstN = 1'b0; supplyOk = 1'b0; mrN = 1'b1; pfCmp = 1'b0;
    repeat (3) step();
    expectOut(1'b1, 1'b0, "R9 reset state");
    rstN = 1'b1;

    // supply still low after reset release
    repeat (2) begin step(); expectOut(1'b1, 1'b0, "R1 R5 supply low"); end

    // power-up: forced pf high while comparator reports failing
    supplyOk = 1'b1;
    recoverCheck(1, "R2 R6 power-up recovery");

    // comparator follow-through, same cycle
    pfCmp = 1'b1; #1 expectOut(1'b0, 1'b1, "R7 follow high");
    pfCmp = 1'b0; #1 expectOut(1'b0, 1'b0, "R7 follow low");
    pfCmp = 1'b1; #1;

    // glitch on manual reset is rejected
    mrN = 1'b0;
    repeat (2) step();
    mrN = 1'b1;
    for (int k = 0; k < 20; k++) begin step(); expectOut(1'b0, 1'b1, "R4 short pulse"); end

    // qualifying manual reset, comparator low to show forcing
    pfCmp = 1'b0;
    manualPress(12, "R3 R6 manual press", 1'b0);
    recoverCheck(SYNC + 1, "R3 R6 manual recovery");

    // second press during recovery restarts the interval
    manualPress(12, "R3 manual press", 1'b0);
    for (int k = 1; k <= 3; k++) begin step(); expectOut(1'b1, 1'b1, "R8 lead"); end
    for (int k = 0; k < 12; k++) begin step(); expectOut(1'b1, 1'b1, "R8 partial recovery"); end
    manualPress(12, "R8 restart press", 1'b1);
    recoverCheck(SYNC + 1, "R8 restarted recovery");

    // supply loss while running, manual pin activity ignored
    pfCmp = 1'b1;
    supplyOk = 1'b0;
    step(); expectOut(1'b1, 1'b0, "R1 R5 loss while running");
    mrN = 1'b0;
    for (int k = 0; k < 12; k++) begin step(); expectOut(1'b1, 1'b0, "R1 R5 mr during loss"); end
    mrN = 1'b1;
    for (int k = 0; k < 5; k++) begin step(); expectOut(1'b1, 1'b0, "R1 R5 hold low"); end
    supplyOk = 1'b1;
    recoverCheck(1, "R2 second power-up");

    // supply loss in the middle of a recovery interval
    supplyOk = 1'b0;
    step(); expectOut(1'b1, 1'b0, "R1 R5 pre-dip");
    supplyOk = 1'b1;
    for (int k = 0; k < 8; k++) step();
    supplyOk = 1'b0;
    step(); expectOut(1'b1, 1'b0, "R1 R5 loss during recovery");
    supplyOk = 1'b1;
    recoverCheck(1, "R2 recovery after dip");

    step();
    done = 1'b1;
    #1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule